// File: doc/BRIEF.md
# Interrupt acknowledge hold controller

This block sits next to the instruction sequencer of a small processor and decides, at every instruction boundary, whether a pending interrupt is taken. The decoder reports each instruction's class together with a completion strobe. The block keeps the global interrupt enable flag, the maskable request flags and a latched non-maskable request. When it accepts a request, it raises a one-cycle acknowledge. That pulse also asks the sequencer to push the status word and program counter. It carries a vector number with it.

Some instructions touch the status word or the interrupt control state. When one of these completes, acceptance is held off past the next boundary as well. A software break is not part of that hold group. It does clear the enable flag, so only the non-maskable request can interrupt it. Among pending requests, the non-maskable one wins. After it comes the high-priority group of unmasked maskable requests, and last the low group. Within a group, the lowest index wins.

Top module: `irq_hold_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, `ack`, `ack_vec`, `ie` and `req_pend` become 0 after that edge, and the hold state is cleared.
- R2: A 1 on `req_set[i]` sets `req_pend[i]` at the next edge, and the flag stays set until it is accepted. `req_mask` and `req_prio` never change `req_pend`.
- R3: Class codes 1 (status-word or interrupt-register access), 3 (enable), 4 (disable) and 5 (return) are hold classes. No request is accepted at the boundary of a hold-class instruction, nor at the next boundary.
- R4: Hold-class instructions in a row keep extending the deferral: the first boundary free of hold is the one after the first non-hold instruction.
- R5: Class code 2 (software break) clears `ie` and blocks maskable acceptance at its own boundary. It is not a hold class, so a pending non-maskable request is accepted at that same boundary.
- R6: While `ie` is 0, maskable requests are never accepted. The non-maskable request, latched from `nmi_set`, is accepted at any boundary free of hold.
- R7: The selection order is: non-maskable first (`ack_vec` = 0); then unmasked pending requests with `req_prio` = 1; then the remaining unmasked pending requests. Within a group the lowest index i wins, and `ack_vec` = i+1.
- R8: `ack` is high for exactly the one cycle after the edge that sampled `instr_done` at an accepting boundary. `ack_vec` is valid in that cycle and 0 otherwise.
- R9: Accepting a maskable request clears `ie` and that request's `req_pend` bit in the `ack` cycle. Accepting the non-maskable request clears its latch and leaves `ie` unchanged.
- R10: At the completion of class 3, `ie` becomes 1. At class 4 it becomes 0. At class 5 it takes the value of `ie_pop`.
- R11: No request is accepted in a cycle without `instr_done`. Classes 0, 6 and 7 are plain instructions.
- R12: If `req_set[i]` is high in the same cycle that request i is accepted, `req_pend[i]` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction completes this cycle (boundary) |
| instr_class | input | 3 | Class code of the completing instruction |
| ie_pop | input | 1 | Enable value restored by a return instruction |
| req_set | input | NREQ | One-cycle pulses that raise maskable request flags |
| req_mask | input | NREQ | 1 masks the request |
| req_prio | input | NREQ | 1 puts the request in the high-priority group |
| nmi_set | input | 1 | Pulse that latches the non-maskable request |
| ack | output | 1 | Acceptance pulse; also the push request for status word and program counter |
| ack_vec | output | $clog2(NREQ+1) | 0 for non-maskable, i+1 for maskable request i |
| ie | output | 1 | Global interrupt enable flag |
| req_pend | output | NREQ | Pending maskable request flags |

## Verification
The bench builds the block with NREQ = 4. At that size every combination of pending flags, masks and priority bits can be swept, with the enable flag both on and off. Each combination passes through an enable instruction and its deferred boundary, so the selection order and the clearing on acceptance are covered for all 4096 request patterns. Directed sequences then cover the chained hold, the software break with and without a non-maskable request, the enable-changing classes, and a request that is set again in the cycle it is accepted.

// File: rtl/irq_hold_ctl.sv
module irq_hold_ctl #(
  parameter int NREQ = 8,
  localparam int VW = $clog2(NREQ + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_done,
  input  logic [2:0]      instr_class,
  input  logic            ie_pop,
  input  logic [NREQ-1:0] req_set,
  input  logic [NREQ-1:0] req_mask,
  input  logic [NREQ-1:0] req_prio,
  input  logic            nmi_set,
  output logic            ack,
  output logic [VW-1:0]   ack_vec,
  output logic            ie,
  output logic [NREQ-1:0] req_pend
);
  localparam logic [2:0] C_SYS = 3'd1;
  localparam logic [2:0] C_BRK = 3'd2;
  localparam logic [2:0] C_EN  = 3'd3;
  localparam logic [2:0] C_DIS = 3'd4;
  localparam logic [2:0] C_RET = 3'd5;

  logic hold_q, nmi_q;
  logic [VW-1:0] pick;
  logic [NREQ-1:0] pick_oh;

  wire is_hold = (instr_class == C_SYS) || (instr_class == C_EN) ||
                 (instr_class == C_DIS) || (instr_class == C_RET);
  wire ie_eff = ie && (instr_class != C_BRK);
  wire [NREQ-1:0] elig = req_pend & ~req_mask & {NREQ{ie_eff}};
  wire [NREQ-1:0] elig_hi = elig & req_prio;
  wire [NREQ-1:0] pool = (|elig_hi) ? elig_hi : elig;

  always_comb begin
    pick = '0;
    pick_oh = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (pool[i]) begin
        pick = VW'(i);
        pick_oh = '0;
        pick_oh[i] = 1'b1;
      end
    end
  end

  wire gate_open = instr_done && !is_hold && !hold_q;
  wire take_nmi = gate_open && nmi_q;
  wire take_mi = gate_open && !nmi_q && (|pool);
  wire [NREQ-1:0] clr = take_mi ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack      <= 1'b0;
      ack_vec  <= '0;
      ie       <= 1'b0;
      req_pend <= '0;
      hold_q   <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      ack      <= take_nmi || take_mi;
      ack_vec  <= take_mi ? pick + VW'(1) : '0;
      req_pend <= (req_pend & ~clr) | req_set;
      nmi_q    <= (nmi_q && !take_nmi) || nmi_set;
      if (instr_done) hold_q <= is_hold;
      if (take_mi) ie <= 1'b0;
      else if (instr_done) begin
        case (instr_class)
          C_EN:    ie <= 1'b1;
          C_DIS:   ie <= 1'b0;
          C_RET:   ie <= ie_pop;
          C_BRK:   ie <= 1'b0;
          default: ie <= ie;
        endcase
      end
    end
  end
endmodule

module irq_hold_chk #(
  parameter int NREQ = 8,
  localparam int VW = $clog2(NREQ + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_done,
  input logic [2:0]    instr_class,
  input logic          nmi_set,
  input logic          ack,
  input logic [VW-1:0] ack_vec,
  input logic          ie,
  input logic          hold_q,
  input logic          nmi_q
);
  wire hold_cls = (instr_class == 3'd1) || (instr_class == 3'd3) ||
                  (instr_class == 3'd4) || (instr_class == 3'd5);

  assert_ack_at_boundary_R11: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(instr_done));

  assert_holdclass_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_done && hold_cls)) |-> !ack);

  assert_deferred_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_done && hold_q)) |-> !ack);

  assert_hold_extends_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_done && hold_cls)) |-> hold_q);

  assert_mi_needs_ie_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ack && ack_vec != '0) |-> ($past(ie) && $past(instr_class) != 3'd2));

  assert_mi_clears_ie_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_vec != '0) |-> !ie);

  assert_nmi_consumed_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ack && ack_vec == '0 && !$past(nmi_set)) |-> !nmi_q);
endmodule

bind irq_hold_ctl irq_hold_chk #(.NREQ(NREQ)) u_irq_hold_chk (
  .clk(clk), .rst(rst), .instr_done(instr_done), .instr_class(instr_class),
  .nmi_set(nmi_set), .ack(ack), .ack_vec(ack_vec), .ie(ie),
  .hold_q(hold_q), .nmi_q(nmi_q)
);

// File: tb/test_irq_hold_ctl.sv
module test_irq_hold_ctl;
  localparam int N = 4;
  localparam int VW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_done = 1'b0;
  logic [2:0] instr_class = 3'd0;
  logic ie_pop = 1'b0;
  logic [N-1:0] req_set = '0, req_mask = '0, req_prio = '0;
  logic nmi_set = 1'b0;
  logic ack, ie;
  logic [VW-1:0] ack_vec;
  logic [N-1:0] req_pend;
  int nchk = 0, nerr = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  irq_hold_ctl #(.NREQ(N)) i_irq_hold_ctl (
    .clk(clk), .rst(rst), .instr_done(instr_done), .instr_class(instr_class),
    .ie_pop(ie_pop), .req_set(req_set), .req_mask(req_mask), .req_prio(req_prio),
    .nmi_set(nmi_set), .ack(ack), .ack_vec(ack_vec), .ie(ie), .req_pend(req_pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setreq(input logic [N-1:0] v);
    req_set = v;
    @(negedge clk);
    req_set = '0;
  endtask

  task automatic boundary(input logic [2:0] c);
    instr_done = 1'b1;
    instr_class = c;
    @(negedge clk);
    instr_done = 1'b0;
    instr_class = 3'd0;
  endtask

  function automatic int exp_vec(input logic [N-1:0] f, input logic [N-1:0] m,
                                 input logic [N-1:0] p);
    logic [N-1:0] el, hi, pool;
    el = f & ~m;
    hi = el & p;
    pool = (hi != 0) ? hi : el;
    if (pool == 0) return 0;
    for (int i = 0; i < N; i++) if (pool[i]) return i + 1;
    return 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ack == 0 && ie == 0 && req_pend == 0 && ack_vec == 0, "R1", {ack, ie}, 0);
    rst = 1'b0;

    // Sweep all flag/mask/priority patterns: R2 R3 R6 R7 R9 R10
    for (int e = 0; e < 2; e++) begin
      for (int f = 0; f < 16; f++) begin
        for (int m = 0; m < 16; m++) begin
          for (int p = 0; p < 16; p++) begin
            do_reset();
            req_mask = N'(m);
            req_prio = N'(p);
            setreq(N'(f));
            chk(req_pend == N'(f), "R2", req_pend, f);
            if (e == 1) begin
              int ev;
              ev = exp_vec(N'(f), N'(m), N'(p));
              boundary(3'd3);
              chk(!ack, "R3", ack, 0);
              chk(ie == 1, "R10", ie, 1);
              boundary(3'd0);
              chk(!ack, "R3", ack, 0);
              boundary(3'd0);
              chk(ack == (ev != 0) && ack_vec == VW'(ev), "R7", ack_vec, ev);
              if (ev != 0) begin
                chk(ie == 0, "R9", ie, 0);
                chk(req_pend == (N'(f) & ~(N'(1) << (ev - 1))), "R9", req_pend,
                    f & ~(1 << (ev - 1)));
              end else chk(ie == 1, "R9", ie, 1);
            end else begin
              boundary(3'd0);
              chk(!ack, "R6", ack, 0);
            end
          end
        end
      end
    end
    req_mask = '0;
    req_prio = '0;

    // R4 chained hold
    do_reset();
    setreq(4'b0100);
    boundary(3'd3);
    boundary(3'd1);
    chk(!ack, "R4", ack, 0);
    boundary(3'd1);
    chk(!ack, "R4", ack, 0);
    boundary(3'd6);
    chk(!ack, "R4", ack, 0);
    boundary(3'd7);
    chk(ack && ack_vec == 3, "R4", ack_vec, 3);
    // R8 single cycle pulse
    @(negedge clk);
    chk(!ack && ack_vec == 0, "R8", ack, 0);

    // R11 no acceptance without a boundary
    do_reset();
    setreq(4'b0001);
    boundary(3'd3);
    boundary(3'd0);
    repeat (5) begin
      @(negedge clk);
      chk(!ack, "R11", ack, 0);
    end
    boundary(3'd0);
    chk(ack && ack_vec == 1, "R11", ack_vec, 1);

    // R5 break blocks maskable, clears ie
    do_reset();
    setreq(4'b0010);
    boundary(3'd3);
    boundary(3'd0);
    boundary(3'd2);
    chk(!ack, "R5", ack, 0);
    chk(ie == 0, "R5", ie, 0);
    boundary(3'd0);
    chk(!ack, "R5", ack, 0);
    chk(req_pend == 4'b0010, "R5", req_pend, 2);

    // R5 break with non-maskable pending: accepted at the break boundary
    nmi_set = 1'b1;
    @(negedge clk);
    nmi_set = 1'b0;
    boundary(3'd2);
    chk(ack && ack_vec == 0, "R5", ack, 1);

    // R6 non-maskable with ie 0, R9 leaves ie unchanged, latch consumed
    do_reset();
    nmi_set = 1'b1;
    @(negedge clk);
    nmi_set = 1'b0;
    boundary(3'd0);
    chk(ack && ack_vec == 0, "R6", ack, 1);
    boundary(3'd0);
    chk(!ack, "R9", ack, 0);
    // non-maskable beats maskable, ie kept
    setreq(4'b0001);
    boundary(3'd3);
    boundary(3'd0);
    nmi_set = 1'b1;
    @(negedge clk);
    nmi_set = 1'b0;
    boundary(3'd0);
    chk(ack && ack_vec == 0, "R7", ack_vec, 0);
    chk(ie == 1, "R9", ie, 1);
    boundary(3'd0);
    chk(ack && ack_vec == 1, "R7", ack_vec, 1);

    // R10 disable and return
    do_reset();
    boundary(3'd3);
    chk(ie == 1, "R10", ie, 1);
    boundary(3'd4);
    chk(ie == 0, "R10", ie, 0);
    ie_pop = 1'b1;
    boundary(3'd5);
    chk(ie == 1, "R10", ie, 1);
    ie_pop = 1'b0;
    boundary(3'd5);
    chk(ie == 0, "R10", ie, 0);

    // R12 set wins over clear
    do_reset();
    setreq(4'b1000);
    boundary(3'd3);
    boundary(3'd0);
    req_set = 4'b1000;
    boundary(3'd0);
    req_set = '0;
    chk(ack && ack_vec == 4, "R12", ack_vec, 4);
    chk(req_pend == 4'b1000, "R12", req_pend, 8);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule